// File: doc/BRIEF.md
# USB 2.0 PHY Port Masked-Write Control and Event Register Bank

This block is a small register bank that sits beside one USB 2.0 PHY port. Software reaches it over a plain 32-bit register bus made of a word address, a write strobe, write data and combinational read data. Every register keeps its data in the lower 16 bits of the word. The upper 16 bits of each write are a per-bit enable, so one field can be changed in a single write with no read-modify-write.

The bank also watches three asynchronous sideband signals from the PHY: VBUS-valid, the ID pin and the 2-bit line state. Each signal passes through a two-flop synchronizer. Four events are then recognised: VBUS-valid rising, ID falling, ID rising and any line-state change. Each event has an enable bit and a sticky status bit. Software clears a status bit by writing 1 to the same bit position with its enable bit set. The interrupt output is the OR of every status bit whose event is enabled.

A control register holds a 9-bit suspend code, which drives the PHY suspend request, and an ID-source select. The select chooses whether the ID value passed upward comes from the PHY pin or from a register bit.

Top module: `usbphy_evt_regbank`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register reads zero. susp_code_o, suspend_o and irq are 0.
- R2: A write to a writable register changes data bit i only when bit 16+i of the same write word is 1; every other bit keeps its value. The new value reads back from the next clock edge on.
- R3: bus_rdata[31:16] always reads zero, and so do the unimplemented lower bits: bits 15:11 at address 0, bits 15:4 at addresses 1 and 2, and bits 15:5 at address 3.
- R4: Control register (address 0) bits 8:0 are the suspend code and drive susp_code_o. suspend_o is 1 exactly when that code is non-zero.
- R5: Control bit 9 selects the ID source. When it is 0, id_out follows the synchronized phy_id pin. When it is 1, id_out equals control bit 10.
- R6: The raw register (address 3) is read-only. Bits 1:0 hold the synchronized line state, bit 2 the synchronized ID pin, bit 3 the synchronized VBUS-valid and bit 4 the reported ID. An input change shows there two clock edges after it is applied. Writes to address 3 have no effect.
- R7: Event bits are ordered the same way in the enable register (address 1) and the status register (address 2): bit 0 is VBUS-valid rise, bit 1 ID fall, bit 2 ID rise and bit 3 line-state change. An enabled event sets its status bit at the third clock edge after the input changes.
- R8: A qualifying edge whose enable bit is 0 leaves the status bit unchanged.
- R9: Writing address 2 with data bit i = 1 and mask bit 16+i = 1 clears status bit i. A data bit of 0, or a mask bit of 0, leaves it set. When a new event and its clear land at the same edge, the bit ends up set.
- R10: irq is 1 exactly when some status bit and its enable bit are both 1. Clearing an enable bit drops irq but leaves the status bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (2) | Word address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write word: upper half is the bit mask, lower half is the data |
| bus_rdata | output | 32 | Combinational read data of the addressed register |
| phy_vbus_valid | input | 1 | Asynchronous VBUS-valid from the PHY |
| phy_id | input | 1 | Asynchronous ID pin from the PHY |
| phy_linestate | input | LS_W (2) | Asynchronous line state from the PHY |
| susp_code_o | output | 9 | Suspend override code sent to the PHY |
| suspend_o | output | 1 | Suspend request, high when the code is non-zero |
| id_out | output | 1 | ID value reported upward |
| irq | output | 1 | Interrupt, OR of the enabled status bits |

## Verification
Every result has a fixed latency. A register write is visible on bus_rdata and on the control outputs one edge after the strobe is sampled. A pin change reaches the raw register and the pin-selected id_out two edges after it is applied, and it sets a status bit and irq three edges after it is applied. The bench changes inputs on falling edges. It samples only on a falling edge after the stated number of rising edges, and for the raw register it also samples one edge early to confirm the old value is still there. The set-versus-clear case lines up the clear strobe with the third rising edge on purpose.

// File: rtl/usbphy_evt_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, register selectors and event bit order for the
// PHY event register bank. Assumes a 32-bit bus word: upper half mask, lower half data.
package usbphy_evt_pkg;
    localparam int HALF_W         = 16;
    localparam int WORD_W         = 2 * HALF_W;
    localparam int SUS_W          = 9;
    localparam int CTRL_IDSEL_BIT = 9;
    localparam int CTRL_IDVAL_BIT = 10;
    localparam int CTRL_W         = 11;
    localparam int N_EVT          = 4;

    // Word address of each register.
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_EVEN = 2'd1,
        SEL_EVST = 2'd2,
        SEL_RAW  = 2'd3
    } reg_sel_e;

    // Bit order of the event enable and status registers.
    localparam int EV_VBUS_RISE = 0;
    localparam int EV_ID_FALL   = 1;
    localparam int EV_ID_RISE   = 2;
    localparam int EV_LS_CHG    = 3;
endpackage

// File: rtl/usbphy_evt_sync.sv
`timescale 1ns/1ps
// Module: multi-stage flop synchronizer for a group of asynchronous PHY inputs.
// Assumes each bit is independent and slow compared with clk; reset clears all stages.
module usbphy_evt_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift one stage per clock, the first stage takes the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg[s] <= '0;
                end else if (s == 0) begin
                    stg[s] <= async_i;
                end else begin
                    stg[s] <= stg[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/usbphy_evt_detect.sv
`timescale 1ns/1ps
// Module: edge detection and sticky status for the four PHY sideband events.
// Assumes synchronized inputs. A status bit sets only while its enable is 1,
// and a set on the same edge as a clear wins.
module usbphy_evt_detect
    import usbphy_evt_pkg::*;
#(
    parameter int LS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vbus_s,
    input  logic             id_s,
    input  logic [LS_W-1:0]  ls_s,
    input  logic [N_EVT-1:0] evt_en,
    input  logic [N_EVT-1:0] evt_clr,
    output logic [N_EVT-1:0] evt_st
);
    logic            vbus_p;
    logic            id_p;
    logic [LS_W-1:0] ls_p;
    logic [N_EVT-1:0] hit;

    // Hold the previous synchronized values for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vbus_p <= 1'b0;
            id_p   <= 1'b0;
            ls_p   <= '0;
        end else begin
            vbus_p <= vbus_s;
            id_p   <= id_s;
            ls_p   <= ls_s;
        end
    end

    // Decode the qualifying edge of each event source.
    always_comb begin
        hit               = '0;
        hit[EV_VBUS_RISE] = vbus_s & ~vbus_p;
        hit[EV_ID_FALL]   = ~id_s & id_p;
        hit[EV_ID_RISE]   = id_s & ~id_p;
        hit[EV_LS_CHG]    = |(ls_s ^ ls_p);
    end

    generate
        for (genvar e = 0; e < N_EVT; e++) begin : g_evt
            // Sticky status: an enabled hit sets it, a software clear drops it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    evt_st[e] <= 1'b0;
                end else if (hit[e] && evt_en[e]) begin
                    evt_st[e] <= 1'b1;
                end else if (evt_clr[e]) begin
                    evt_st[e] <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/usbphy_evt_ctrl.sv
`timescale 1ns/1ps
// Module: bit-masked control and event-enable registers.
// Assumes a one-cycle write strobe per register; bit i is written only when
// mask bit HALF_W+i of the write word is 1.
module usbphy_evt_ctrl
    import usbphy_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [N_EVT-1:0]  en_q
);
    generate
        for (genvar b = 0; b < CTRL_W; b++) begin : g_ctrl
            // Update one control bit when its own mask bit is set.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ctrl_q[b] <= 1'b0;
                end else if (wr_ctrl && wdata[HALF_W+b]) begin
                    ctrl_q[b] <= wdata[b];
                end
            end
        end
        for (genvar b = 0; b < N_EVT; b++) begin : g_en
            // Update one event-enable bit when its own mask bit is set.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_q[b] <= 1'b0;
                end else if (wr_en && wdata[HALF_W+b]) begin
                    en_q[b] <= wdata[b];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/usbphy_evt_regbank.sv
`timescale 1ns/1ps
// Module: top of the PHY port register bank. Decodes the register bus, syncs the
// PHY sideband inputs, selects the reported ID and drives suspend and interrupt.
// Assumes reads are combinational and writes take effect at the next clock edge.
module usbphy_evt_regbank
    import usbphy_evt_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int LS_W        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              phy_vbus_valid,
    input  logic              phy_id,
    input  logic [LS_W-1:0]   phy_linestate,
    output logic [SUS_W-1:0]  susp_code_o,
    output logic              suspend_o,
    output logic              id_out,
    output logic              irq
);
    localparam int SYNC_W = LS_W + 2;
    localparam int RAW_W  = LS_W + 3;

    logic [CTRL_W-1:0] ctrl_q;
    logic [N_EVT-1:0]  evt_en;
    logic [N_EVT-1:0]  evt_st;
    logic [N_EVT-1:0]  evt_clr;
    logic [SYNC_W-1:0] sync_v;
    logic              vbus_s;
    logic              id_s;
    logic [LS_W-1:0]   ls_s;
    logic              sel_ctrl, sel_en, sel_st, sel_raw;
    logic [RAW_W-1:0]  raw_v;

    // Address decode for the four registers.
    assign sel_ctrl = (bus_addr == ADDR_W'(SEL_CTRL));
    assign sel_en   = (bus_addr == ADDR_W'(SEL_EVEN));
    assign sel_st   = (bus_addr == ADDR_W'(SEL_EVST));
    assign sel_raw  = (bus_addr == ADDR_W'(SEL_RAW));

    usbphy_evt_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({phy_vbus_valid, phy_id, phy_linestate}),
        .sync_o  (sync_v)
    );

    assign ls_s   = sync_v[LS_W-1:0];
    assign id_s   = sync_v[LS_W];
    assign vbus_s = sync_v[LS_W+1];

    usbphy_evt_ctrl ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (bus_wr && sel_ctrl),
        .wr_en   (bus_wr && sel_en),
        .wdata   (bus_wdata),
        .ctrl_q  (ctrl_q),
        .en_q    (evt_en)
    );

    // Clear request: data 1 with its mask bit set, on a status-register write.
    assign evt_clr = (bus_wr && sel_st) ?
                     (bus_wdata[N_EVT-1:0] & bus_wdata[HALF_W +: N_EVT]) : '0;

    usbphy_evt_detect #(.LS_W(LS_W)) det_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .vbus_s  (vbus_s),
        .id_s    (id_s),
        .ls_s    (ls_s),
        .evt_en  (evt_en),
        .evt_clr (evt_clr),
        .evt_st  (evt_st)
    );

    // Reported ID: register value when selected, otherwise the synced pin.
    assign id_out      = ctrl_q[CTRL_IDSEL_BIT] ? ctrl_q[CTRL_IDVAL_BIT] : id_s;
    assign susp_code_o = ctrl_q[SUS_W-1:0];
    assign suspend_o   = |ctrl_q[SUS_W-1:0];
    assign irq         = |(evt_st & evt_en);
    assign raw_v       = {id_out, vbus_s, id_s, ls_s};

    // Read mux; the upper half and unimplemented bits return zero.
    always_comb begin
        bus_rdata = '0;
        unique case (1'b1)
            sel_ctrl: bus_rdata[CTRL_W-1:0] = ctrl_q;
            sel_en:   bus_rdata[N_EVT-1:0]  = evt_en;
            sel_st:   bus_rdata[N_EVT-1:0]  = evt_st;
            sel_raw:  bus_rdata[RAW_W-1:0]  = raw_v;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/usbphy_evt_regbank_chk.sv
`timescale 1ns/1ps
// Module: assertion checker bound to usbphy_evt_regbank. Relates bus writes,
// register outputs and event status over time. Assumes reset is held for at least one edge.
module usbphy_evt_regbank_chk
    import usbphy_evt_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [SUS_W-1:0]  susp_code_o,
    input logic              irq,
    input logic [N_EVT-1:0]  evt_en,
    input logic [N_EVT-1:0]  evt_st
);
    logic [N_EVT-1:0] chk_clr;
    logic             wr_ctrl;

    // Clear request as software intends it, rebuilt from the bus.
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(SEL_CTRL));
    assign chk_clr = (bus_wr && (bus_addr == ADDR_W'(SEL_EVST))) ?
                     (bus_wdata[N_EVT-1:0] & bus_wdata[HALF_W +: N_EVT]) : '0;

    // R3
    upper_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:16] == 16'h0);

    // R4
    susp_full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && (&bus_wdata[HALF_W +: SUS_W])) |=> (susp_code_o == $past(bus_wdata[SUS_W-1:0])));

    // R2
    susp_unmasked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && (bus_wdata[HALF_W +: SUS_W] == '0)) |=> $stable(susp_code_o));

    // R8
    status_set_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_st & ~$past(evt_st)) & ~$past(evt_en)) == '0);

    // R9
    status_drop_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(evt_st) & ~evt_st) & ~$past(chk_clr)) == '0);

    // R10
    irq_idle_no_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_en == '0) |-> !irq);
endmodule

bind usbphy_evt_regbank usbphy_evt_regbank_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .susp_code_o (susp_code_o),
    .irq         (irq),
    .evt_en      (evt_en),
    .evt_st      (evt_st)
);

// File: tb/usbphy_evt_regbank_tb.sv
`timescale 1ns/1ps
// Bench: sweeps masked writes and every event source with enable on and off.
// Expected values come from the requirements, computed in the bench.
module usbphy_evt_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        phy_vbus_valid = 1'b0;
    logic        phy_id = 1'b1;
    logic [1:0]  phy_linestate = 2'b00;
    logic [8:0]  susp_code_o;
    logic        suspend_o;
    logic        id_out;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    usbphy_evt_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .phy_vbus_valid(phy_vbus_valid), .phy_id(phy_id), .phy_linestate(phy_linestate),
        .susp_code_o(susp_code_o), .suspend_o(suspend_o), .id_out(id_out), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_reg(input logic [1:0] a, input logic [31:0] exp, input string req);
        logic [31:0] d;
        rd(a, d);
        check(d == exp, req, d, exp);
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive the qualifying edge of event k from the idle pin state.
    task automatic fire(input int k);
        case (k)
            0: phy_vbus_valid = 1'b1;
            1: phy_id = 1'b0;
            2: phy_id = 1'b1;
            default: phy_linestate = 2'b10;
        endcase
    endtask

    task automatic idle_pins();
        phy_vbus_valid = 1'b0; phy_id = 1'b1; phy_linestate = 2'b00;
    endtask

    initial begin
        logic [15:0] exp_ctrl;
        logic [15:0] exp_en;
        logic [31:0] lfsr;
        logic [31:0] d;
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(4);

        // R1: reset state
        chk_reg(2'd0, 32'h0, "R1 ctrl");
        chk_reg(2'd1, 32'h0, "R1 enable");
        chk_reg(2'd2, 32'h0, "R1 status");
        check(susp_code_o == 9'd0 && !suspend_o && !irq, "R1 outputs",
              {21'd0, susp_code_o, suspend_o, irq}, 32'h0);

        // R2 R3 R4: masked-write sweep over the control and enable registers
        exp_ctrl = '0; exp_en = '0; lfsr = 32'h1d2c_3b4a;
        for (int i = 0; i < 64; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (i[0] == 1'b0) begin
                wr(2'd0, lfsr);
                exp_ctrl = ((exp_ctrl & ~lfsr[31:16]) | (lfsr[15:0] & lfsr[31:16])) & 16'h07FF;
                chk_reg(2'd0, {16'h0, exp_ctrl}, "R2 R3 ctrl masked write");
                check(susp_code_o == exp_ctrl[8:0] && suspend_o == (exp_ctrl[8:0] != 0),
                      "R4 suspend outputs", {22'd0, suspend_o, susp_code_o},
                      {22'd0, exp_ctrl[8:0] != 0, exp_ctrl[8:0]});
            end else begin
                wr(2'd1, lfsr);
                exp_en = ((exp_en & ~lfsr[31:16]) | (lfsr[15:0] & lfsr[31:16])) & 16'h000F;
                chk_reg(2'd1, {16'h0, exp_en}, "R2 R3 enable masked write");
            end
        end
        wr(2'd0, 32'hFFFF_0000);
        wr(2'd1, 32'hFFFF_0000);
        wr(2'd2, 32'h000F_000F);
        chk_reg(2'd0, 32'h0, "R2 full-mask zero write");

        // R5: ID source select
        wait_neg(3);
        check(id_out == 1'b1, "R5 id from pin high", {31'd0, id_out}, 32'd1);
        wr(2'd0, 32'h0600_0200);
        check(id_out == 1'b0, "R5 id from register 0", {31'd0, id_out}, 32'd0);
        wr(2'd0, 32'h0400_0400);
        check(id_out == 1'b1, "R5 id from register 1", {31'd0, id_out}, 32'd1);
        wr(2'd0, 32'h0600_0000);

        // R6: raw register latency and write immunity
        phy_vbus_valid = 1'b1; phy_linestate = 2'b11; phy_id = 1'b0;
        wait_neg(1);
        chk_reg(2'd3, 32'h0000_0014, "R6 raw before two edges");
        wait_neg(1);
        chk_reg(2'd3, 32'h0000_000B, "R6 raw after two edges");
        check(id_out == 1'b0, "R5 id follows pin low", {31'd0, id_out}, 32'd0);
        wr(2'd3, 32'hFFFF_FFFF);
        chk_reg(2'd3, 32'h0000_000B, "R6 raw write ignored");
        idle_pins();
        wait_neg(4);
        wr(2'd2, 32'h000F_000F);
        chk_reg(2'd2, 32'h0, "R6 status untouched with enables off");

        // R7 R8 R10: each source with its enable on and off
        for (int k = 0; k < 4; k++) begin
            for (int on = 0; on < 2; on++) begin
                if (k == 2) begin
                    phy_id = 1'b0;
                    wait_neg(4);
                end
                wr(2'd1, on != 0 ? (32'h000F_0000 | (32'd1 << k)) : 32'h000F_0000);
                fire(k);
                wait_neg(2);
                chk_reg(2'd2, 32'h0, "R7 status not set before third edge");
                wait_neg(1);
                chk_reg(2'd2, on != 0 ? (32'd1 << k) : 32'd0, on != 0 ? "R7 enabled event sets" : "R8 disabled event ignored");
                check(irq == (on != 0), "R10 irq follows enabled status", {31'd0, irq}, {31'd0, on != 0});
                wr(2'd1, 32'h000F_0000);
                check(!irq, "R10 irq drops with enable", {31'd0, irq}, 32'd0);
                chk_reg(2'd2, on != 0 ? (32'd1 << k) : 32'd0, "R10 status kept when enable clears");
                idle_pins();
                wait_neg(4);
                wr(2'd2, 32'h000F_000F);
                chk_reg(2'd2, 32'h0, "R9 clear all");
            end
        end

        // R9: clear qualifiers
        wr(2'd1, 32'h000F_000F);
        fire(0);
        wait_neg(3);
        wr(2'd2, 32'h0000_0001);
        chk_reg(2'd2, 32'h1, "R9 clear without mask ignored");
        wr(2'd2, 32'h0001_0000);
        chk_reg(2'd2, 32'h1, "R9 mask without data ignored");
        wr(2'd2, 32'h0001_0001);
        chk_reg(2'd2, 32'h0, "R9 masked clear");
        check(!irq, "R10 irq low after clear", {31'd0, irq}, 32'd0);

        // R9: set and clear at the same edge, set wins
        fire(3);
        wait_neg(2);
        wr(2'd2, 32'h0008_0008);
        chk_reg(2'd2, 32'h8, "R9 set wins over same-edge clear");
        check(irq, "R10 irq high after set-wins", {31'd0, irq}, 32'd1);
        wr(2'd2, 32'h0008_0008);
        chk_reg(2'd2, 32'h0, "R9 later clear");

        rd(2'd2, d);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule